// File: doc/BRIEF.md
# Dual Four-Mode Down-Counter Timer

This block holds two 16-bit down-counters and reuses them in one of four modes. The modes are pulse-width modulation, dual input capture, two independent periodic timers, and a combined mode with one periodic timer and one external event counter. Both counters share two reload values, two external input pins and a common run control. The outputs are the counter values, two capture registers, a waveform pin and four sticky event flags.

A controlling agent stops the block, programs the mode, the reload values and the edge polarity, and then raises `run_i`. `tick_i` is a prescaled clock enable and advances the periodic counters. `pin_a_i` and `pin_b_i` are synchronous external inputs. Their selected edges either capture the first counter or step the second counter. Flags stay set until they are cleared through `clr_i`.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset, both counters, both capture registers, `pwm_o` and all four flags are zero.
- R2: While `run_i` is low, counter 1 loads `rld_b_i` in mode 0 and `rld_a_i` in any other mode. Counter 2 loads 16'hFFFF in mode 0 and `rld_b_i` in any other mode. `pwm_o` is low.
- R3: The mode field (`mode_i`: 0 = PWM, 1 = dual capture, 2 = dual timer, 3 = combined) is taken only while `run_i` is low. A change made while running has no effect until the block is stopped.
- R4: While running, a counter decrements once per step event. A step at value zero reloads the counter instead and sets its underflow flag (`flags_o[0]` for counter 1, `flags_o[1]` for counter 2). With `tick_i` low, the tick-driven counters hold their value.
- R5: In mode 0, each underflow of counter 1 toggles `pwm_o`. Counter 1 reloads `rld_a_i` when `pwm_o` goes high and `rld_b_i` when it goes low, so the high time is A+1 ticks and the low time is B+1 ticks, starting low. Counter 2 runs freely on ticks and reloads 16'hFFFF.
- R6: In mode 1, counter 1 runs on ticks with reload A. A selected edge on `pin_a_i` copies counter 1's value before that cycle's update into `cap_a_o` and sets `flags_o[2]`. A selected edge on `pin_b_i` does the same into `cap_b_o` and sets `flags_o[3]`. Counter 2 holds its value.
- R7: `edge_sel_i[0]` selects the edge for `pin_a_i` and `edge_sel_i[1]` selects it for `pin_b_i`. A value of 0 selects the rising edge and 1 selects the falling edge. The other edge is ignored.
- R8: In mode 2, both counters run on ticks, counter 1 with reload A and counter 2 with reload B.
- R9: In mode 3, counter 1 runs on ticks with reload A, and a selected edge on `pin_a_i` captures it as in R6. Counter 2 ignores ticks and decrements once per selected edge on `pin_b_i`, with reload B.
- R10: A high bit of `clr_i` clears the flag at the same position. A flag set in the same cycle stays set.
- R11: Pin edges while `run_i` is low change neither capture register nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Counters run when high; load reload values when low |
| mode_i | input | 2 | Operating mode, taken while stopped |
| tick_i | input | 1 | Prescaled clock enable for periodic counting |
| rld_a_i | input | 16 | Reload value A |
| rld_b_i | input | 16 | Reload value B |
| edge_sel_i | input | 2 | Edge polarity per pin (0 rising, 1 falling) |
| pin_a_i | input | 1 | External input A (synchronous) |
| pin_b_i | input | 1 | External input B (synchronous) |
| clr_i | input | 4 | Flag clear strobes |
| cnt1_o | output | 16 | Counter 1 value |
| cnt2_o | output | 16 | Counter 2 value |
| cap_a_o | output | 16 | Capture register A |
| cap_b_o | output | 16 | Capture register B |
| pwm_o | output | 1 | Waveform output |
| flags_o | output | 4 | {capture B, capture A, underflow 2, underflow 1} |

## Verification
A capture edge and a counter-1 underflow can land on the same clock. When they do, the capture register must receive the pre-reload value zero, the counter must be back at A, and both the capture and underflow flags must be set. The bench provokes this by counting counter 1 down in capture mode and raising `pin_a_i` in the cycle where the counter reads zero. It then checks `cap_a_o`, `cnt1_o` and both flags one cycle later. A clear strobe is then applied to one flag alone to show that the other flag survives.

// File: rtl/mft_pkg.sv
package mft_pkg;
  typedef enum logic [1:0] {
    MODE_PWM     = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_DUAL    = 2'd2,
    MODE_COMBO   = 2'd3
  } mft_mode_e;
endpackage

// File: rtl/mft_edge.sv
module mft_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_i;
  end

  assign edge_o = fall_i ? (prev_q & ~pin_i) : (~prev_q & pin_i);
endmodule

// File: rtl/mft_counter.sv
module mft_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  input  logic [W-1:0] reload_val_i,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q;

  assign uf_o = dec_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (uf_o)   cnt_q <= reload_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  // R4
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && dec_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R4
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && dec_i && cnt_q == '0) |=> (cnt_q == $past(reload_val_i)));
  // R2
  stop_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import mft_pkg::*;
#(
  parameter int W  = 16,
  parameter int NF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [1:0]    mode_i,
  input  logic          tick_i,
  input  logic [W-1:0]  rld_a_i,
  input  logic [W-1:0]  rld_b_i,
  input  logic [1:0]    edge_sel_i,
  input  logic          pin_a_i,
  input  logic          pin_b_i,
  input  logic [NF-1:0] clr_i,
  output logic [W-1:0]  cnt1_o,
  output logic [W-1:0]  cnt2_o,
  output logic [W-1:0]  cap_a_o,
  output logic [W-1:0]  cap_b_o,
  output logic          pwm_o,
  output logic [NF-1:0] flags_o
);
  localparam int NCH = 2;
  localparam logic [W-1:0] FREE_RELOAD = {W{1'b1}};

  mft_mode_e mode_q, mode_d;
  logic [1:0] pins, edges;
  logic [NCH-1:0][W-1:0] ld_val, rl_val, cnt;
  logic [NCH-1:0] dec, uf;
  logic pwm_q;
  logic cap_a_en, cap_b_en;
  logic [W-1:0] cap_a_q, cap_b_q;
  logic [NF-1:0] flag_q, flag_set;

  // mode is frozen while running
  assign mode_d = run_i ? mode_q : mft_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_PWM;
    else         mode_q <= mode_d;
  end

  assign pins = {pin_b_i, pin_a_i};

  always_comb begin
    ld_val[0] = (mode_d == MODE_PWM) ? rld_b_i : rld_a_i;
    rl_val[0] = (mode_q == MODE_PWM) ? (pwm_q ? rld_b_i : rld_a_i) : rld_a_i;
    ld_val[1] = (mode_d == MODE_PWM) ? FREE_RELOAD : rld_b_i;
    rl_val[1] = (mode_q == MODE_PWM) ? FREE_RELOAD : rld_b_i;
    dec[0]    = run_i & tick_i;
    unique case (mode_q)
      MODE_PWM, MODE_DUAL: dec[1] = run_i & tick_i;
      MODE_COMBO:          dec[1] = run_i & edges[1];
      default:             dec[1] = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    mft_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins[i]),
      .fall_i (edge_sel_i[i]),
      .edge_o (edges[i])
    );
    mft_counter #(.W(W)) u_cnt (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (!run_i),
      .load_val_i   (ld_val[i]),
      .dec_i        (dec[i]),
      .reload_val_i (rl_val[i]),
      .cnt_o        (cnt[i]),
      .uf_o         (uf[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          pwm_q <= 1'b0;
    else if (!run_i)                      pwm_q <= 1'b0;
    else if (mode_q == MODE_PWM && uf[0]) pwm_q <= ~pwm_q;
  end

  assign cap_a_en = run_i & edges[0] & (mode_q == MODE_CAPTURE || mode_q == MODE_COMBO);
  assign cap_b_en = run_i & edges[1] & (mode_q == MODE_CAPTURE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_a_q <= '0;
      cap_b_q <= '0;
    end else begin
      if (cap_a_en) cap_a_q <= cnt[0];
      if (cap_b_en) cap_b_q <= cnt[0];
    end
  end

  assign flag_set = {cap_b_en, cap_a_en, uf[1], uf[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_set | (flag_q & ~clr_i);
  end

  assign cnt1_o  = cnt[0];
  assign cnt2_o  = cnt[1];
  assign cap_a_o = cap_a_q;
  assign cap_b_o = cap_b_q;
  assign pwm_o   = pwm_q;
  assign flags_o = flag_q;

  // R3
  mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> $stable(mode_q));
  // R5
  pwm_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !uf[0]) |=> $stable(pwm_q));
  // R2
  pwm_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !pwm_q);
  // R10
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf[0] || uf[1]) |=> (flag_q[0] || flag_q[1]));
  // R11
  stop_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(cap_a_q) && $stable(cap_b_q)));
endmodule

// File: tb/dual_mode_timer_test.sv
module dual_mode_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic        clk = 0, rst_ni = 0, run = 0, tick = 0, pin_a = 0, pin_b = 0;
  logic [1:0]  mode = 0, esel = 0;
  logic [15:0] rld_a = 0, rld_b = 0;
  logic [3:0]  clr = 0;
  logic [15:0] cnt1, cnt2, cap_a, cap_b;
  logic        pwm;
  logic [3:0]  flags;
  int n_run = 0, n_fail = 0;

  // {mode, A, B, ticks, exp cnt1, exp cnt2, exp pwm, exp {uf2,uf1}}
  localparam logic [76:0] VEC [NV] = '{
    {2'd2, 16'd5, 16'd3, 8'd4, 16'd1, 16'd3,      1'b0, 2'b10}, // R8
    {2'd2, 16'd2, 16'd9, 8'd7, 16'd1, 16'd2,      1'b0, 2'b01}, // R8
    {2'd0, 16'd2, 16'd1, 8'd1, 16'd0, 16'hFFFE,   1'b0, 2'b00}, // R5
    {2'd0, 16'd2, 16'd1, 8'd2, 16'd2, 16'hFFFD,   1'b1, 2'b01}, // R5
    {2'd0, 16'd2, 16'd1, 8'd5, 16'd1, 16'hFFFA,   1'b0, 2'b01}, // R5
    {2'd0, 16'd0, 16'd0, 8'd3, 16'd0, 16'hFFFC,   1'b1, 2'b01}, // R5
    {2'd1, 16'd4, 16'd7, 8'd6, 16'd3, 16'd7,      1'b0, 2'b01}, // R6
    {2'd3, 16'd3, 16'd6, 8'd4, 16'd3, 16'd6,      1'b0, 2'b01}  // R9
  };

  dual_mode_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run), .mode_i(mode), .tick_i(tick),
    .rld_a_i(rld_a), .rld_b_i(rld_b), .edge_sel_i(esel), .pin_a_i(pin_a),
    .pin_b_i(pin_b), .clr_i(clr), .cnt1_o(cnt1), .cnt2_o(cnt2),
    .cap_a_o(cap_a), .cap_b_o(cap_b), .pwm_o(pwm), .flags_o(flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(logic [1:0] m, logic [15:0] a, logic [15:0] b);
    run = 0; mode = m; rld_a = a; rld_b = b; clr = 4'hF;
    cyc(1);
    clr = 0;
    cyc(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(2);
    chk("R1 cnt1", cnt1, 0);
    chk("R1 cnt2", cnt2, 0);
    chk("R1 caps", {cap_a, cap_b}, 0);
    chk("R1 pwm/flags", {pwm, flags}, 0);
    rst_ni = 1;
    cyc(1);

    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][76:75], VEC[i][74:59], VEC[i][58:43]);
      tick = 1; run = 1;
      cyc(int'(VEC[i][42:35]));
      chk($sformatf("R4 vec%0d cnt1", i), cnt1, VEC[i][34:19]);
      chk($sformatf("R4 vec%0d cnt2", i), cnt2, VEC[i][18:3]);
      chk($sformatf("R5 vec%0d pwm", i), pwm, VEC[i][2]);
      chk($sformatf("R10 vec%0d uf flags", i), flags[1:0], VEC[i][1:0]);
      run = 0;
    end

    // R6 capture on rising A, R7 falling select on B
    esel = 2'b10;
    setup(2'd1, 16'd100, 16'd0);
    tick = 1; run = 1;
    cyc(10);
    chk("R6 cnt1 before", cnt1, 90);
    pin_a = 1;
    cyc(1);
    chk("R6 cap_a", cap_a, 90);
    chk("R6 cap flags", flags[3:2], 2'b01);
    pin_b = 1;
    cyc(1);
    chk("R7 rising B ignored", flags[3], 0);
    pin_b = 0;
    cyc(1);
    chk("R7 falling B cap", cap_b, 88);
    chk("R7 falling B flag", flags[3], 1);
    chk("R6 cnt2 held", cnt2, 0);

    // R11 edges while stopped
    run = 0; clr = 4'hF; pin_a = 0;
    cyc(1);
    clr = 0; pin_a = 1;
    cyc(1);
    cyc(1);
    chk("R11 cap_a unchanged", cap_a, 90);
    chk("R11 flag clear", flags, 0);

    // capture coinciding with underflow
    esel = 2'b00; pin_a = 0;
    setup(2'd1, 16'd3, 16'd0);
    tick = 1; run = 1;
    cyc(3);
    chk("R4 cnt1 zero", cnt1, 0);
    pin_a = 1;
    cyc(1);
    chk("R6 coincident cap", cap_a, 0);
    chk("R4 coincident reload", cnt1, 3);
    chk("R10 both flags", {flags[2], flags[0]}, 2'b11);
    clr = 4'b0001;
    cyc(1);
    clr = 0;
    chk("R10 selective clear", {flags[2], flags[0]}, 2'b10);
    run = 0; pin_a = 0;

    // R9 combined mode: counter 2 steps on B edges only
    setup(2'd3, 16'd50, 16'd2);
    tick = 0; run = 1;
    cyc(3);
    chk("R4 tick low holds", cnt1, 50);
    chk("R9 cnt2 no edge", cnt2, 2);
    for (int k = 0; k < 3; k++) begin
      pin_b = 1; cyc(1);
      pin_b = 0; cyc(1);
    end
    chk("R9 cnt2 reload", cnt2, 2);
    chk("R9 uf2 flag", flags[1], 1);
    chk("R9 cnt1 untouched", cnt1, 50);
    run = 0;

    // R3 mode change ignored while running
    setup(2'd2, 16'd1, 16'd20);
    tick = 1; run = 1;
    cyc(1);
    mode = 2'd0;
    for (int k = 0; k < 4; k++) begin
      cyc(1);
      chk("R3 pwm stays low", pwm, 0);
    end
    chk("R8 cnt1", cnt1, 0);
    chk("R8 cnt2", cnt2, 15);
    run = 0;
    cyc(1);
    chk("R2 load cnt1", cnt1, 20);
    chk("R2 load cnt2", cnt2, 16'hFFFF);
    chk("R2 pwm low", pwm, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule